// File: doc/BRIEF.md
# Multimedia Subgroup-2 Lower-Lane Copy Unit

This unit sits in the execute stage of a core whose general registers are 128 bits wide. It takes one instruction word per cycle with its program counter and the two 128-bit source operands already read from the register file. It recognises the multimedia extension space of the instruction set. Inside that space it carries out one operation, a cross copy of the lower 64-bit lanes: the lower lane of the first source goes to the upper lane of the result, and the lower lane of the second source goes to the lower lane of the result.

Decoding has three levels. The primary opcode selects the extension space. The function code then picks one of four subgroup tables. Inside the second subgroup, the shift-amount field picks the operation. Any other instruction that lands in the extension space is never dropped silently. It raises an unsupported-instruction trap, and the trap carries the program counter and the instruction word of the offending instruction, so the pipeline can report exactly what was missing. Instructions outside the extension space are left to other units: this unit neither writes nor traps on them.

All outputs are registered and appear one clock after the input was presented. The write strobe and the trap strobe are single-cycle pulses.

Top module: `simd_copy_unit`

## Requirements
- R1: While reset is asserted and right after it, `wr_en_o` and `trap_o` are 0, and `result_o`, `dest_o`, `trap_pc_o` and `trap_word_o` are all 0.
- R2: A valid instruction with opcode bits [31:26] = 0x1C, function bits [5:0] = 0x09 and shift-amount bits [10:6] = 0x0E, whose destination field bits [15:11] is not 0, raises `wr_en_o` for exactly one cycle, one clock later. `dest_o` then equals bits [15:11].
- R3: With that write, `result_o[127:64]` equals `src_a_i[63:0]` and `result_o[63:0]` equals `src_b_i[63:0]`. The upper 64 bits of both sources have no effect.
- R4: The same copy with destination field 0 leaves `wr_en_o` and `trap_o` low. `result_o` and `dest_o` keep their previous values.
- R5: Any other valid instruction with opcode 0x1C raises `trap_o` for one cycle, one clock later, with `wr_en_o` low. This covers every function code, including 0x08, 0x28 and 0x29 (the other three subgroup tables) and 0x09 with a shift amount other than 0x0E. `trap_pc_o` and `trap_word_o` then show that instruction's PC and word.
- R6: A valid instruction whose opcode is not 0x1C leaves `wr_en_o` and `trap_o` low and changes none of the held outputs, whatever its other fields hold.
- R7: While `valid_i` is low, the next cycle shows `wr_en_o` and `trap_o` low and the held outputs unchanged.
- R8: `trap_pc_o` and `trap_word_o` hold the last trap's values until the next trap. `result_o` and `dest_o` hold the last write's values until the next write. Back-to-back instructions are each reported in their own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction on the inputs is live this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Program counter of the instruction |
| src_a_i | input | 128 | First source operand (rs) |
| src_b_i | input | 128 | Second source operand (rt) |
| result_o | output | 128 | Result of the last write |
| dest_o | output | 5 | Destination register index of the last write |
| wr_en_o | output | 1 | One-cycle write strobe for the register file |
| trap_o | output | 1 | One-cycle unsupported-instruction trap |
| trap_pc_o | output | 32 | PC of the last trapped instruction |
| trap_word_o | output | 32 | Word of the last trapped instruction |

## Verification
Every result of this unit falls due exactly one clock edge after the edge that captured its instruction. This holds for the write strobe, the trap strobe, the copied lanes and the trap report. The bench therefore stamps each expected item with the cycle number at which it is due, and the monitor compares it a short time after that edge. Idle and foreign-opcode cycles also push expected items, so every cycle checks that the strobes are quiet and the held values stand still. The in-RTL properties use a one-cycle `$past` against the same latency.

// File: rtl/scd_pkg.sv
package scd_pkg;

  // Instruction field positions (behavioural: the decode depends on them)
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int OPC_HI    = 31;
  localparam int OPC_LO    = 26;
  localparam int DST_HI    = 15;
  localparam int DST_LO    = 11;
  localparam int SHAMT_HI  = 10;
  localparam int SHAMT_LO  = 6;
  localparam int FN_HI     = 5;
  localparam int FN_LO     = 0;

  // Extension-space selector and subgroup function codes
  localparam logic [5:0] OPC_MEDIA  = 6'h1C;
  localparam logic [5:0] FN_GROUP0  = 6'h08;
  localparam logic [5:0] FN_GROUP1  = 6'h28;
  localparam logic [5:0] FN_GROUP2  = 6'h09;
  localparam logic [5:0] FN_GROUP3  = 6'h29;
  localparam logic [4:0] SA_COPY_LO = 5'h0E;

  typedef enum logic [2:0] {
    SG_NONE,
    SG_T0,
    SG_T1,
    SG_T2,
    SG_T3
  } subgroup_e;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_PASS,
    ACT_COPY,
    ACT_TRAP
  } action_e;

  function automatic subgroup_e subgroup_of(input logic [5:0] fn);
    unique case (fn)
      FN_GROUP0: subgroup_of = SG_T0;
      FN_GROUP1: subgroup_of = SG_T1;
      FN_GROUP2: subgroup_of = SG_T2;
      FN_GROUP3: subgroup_of = SG_T3;
      default:   subgroup_of = SG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/scd_decode.sv
module scd_decode
  import scd_pkg::*;
(
  input  logic                 valid,
  input  logic [INSTR_W-1:0]   instr,
  output action_e              action,
  output logic                 copy_hit,
  output logic                 trap_hit,
  output logic                 write_req,
  output logic [REG_IDX_W-1:0] dst_idx
);

  logic [5:0]           opc;
  logic [5:0]           fn;
  logic [4:0]           shamt;
  logic                 in_media;
  subgroup_e            group;
  logic [9:0]           unused_src_fields;

  assign opc      = instr[OPC_HI:OPC_LO];
  assign fn       = instr[FN_HI:FN_LO];
  assign shamt    = instr[SHAMT_HI:SHAMT_LO];
  assign dst_idx  = instr[DST_HI:DST_LO];
  assign in_media = (opc == OPC_MEDIA);
  assign group    = subgroup_of(fn);

  // Source indices are resolved by the register file, not here.
  assign unused_src_fields = instr[25:16];

  // Level 1: opcode; level 2: subgroup table; level 3: shift-amount arm.
  always_comb begin
    action = ACT_IDLE;
    if (valid) begin
      if (!in_media) begin
        action = ACT_PASS;
      end else begin
        action = ACT_TRAP;
        unique case (group)
          SG_T2: begin
            if (shamt == SA_COPY_LO) action = ACT_COPY;
          end
          SG_T0, SG_T1, SG_T3: action = ACT_TRAP;
          default:             action = ACT_TRAP;
        endcase
      end
    end
  end

  assign copy_hit  = (action == ACT_COPY);
  assign trap_hit  = (action == ACT_TRAP);
  assign write_req = copy_hit && (dst_idx != '0);

endmodule

// File: rtl/scd_lane_cross.sv
module scd_lane_cross #(
  parameter int XLEN = 128
) (
  input  logic [XLEN/2-1:0] hi_lane_src,
  input  logic [XLEN/2-1:0] lo_lane_src,
  output logic [XLEN-1:0]   merged
);

  localparam int LANE = XLEN / 2;

  function automatic logic [XLEN-1:0] cross_lower(
    input logic [LANE-1:0] upper_from,
    input logic [LANE-1:0] lower_from
  );
    cross_lower = {upper_from, lower_from};
  endfunction

  assign merged = cross_lower(hi_lane_src, lo_lane_src);

endmodule

// File: rtl/scd_commit.sv
module scd_commit
  import scd_pkg::*;
#(
  parameter int XLEN = 128,
  parameter int PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 write_req,
  input  logic                 trap_hit,
  input  logic [XLEN-1:0]      value,
  input  logic [REG_IDX_W-1:0] dst_idx,
  input  logic [PC_W-1:0]      pc,
  input  logic [INSTR_W-1:0]   instr,
  output logic [XLEN-1:0]      result_q,
  output logic [REG_IDX_W-1:0] dest_q,
  output logic                 wr_en_q,
  output logic                 trap_q,
  output logic [PC_W-1:0]      trap_pc_q,
  output logic [INSTR_W-1:0]   trap_word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      wr_en_q <= write_req;
      trap_q  <= trap_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      dest_q   <= '0;
    end else if (write_req) begin
      result_q <= value;
      dest_q   <= dst_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_pc_q   <= '0;
      trap_word_q <= '0;
    end else if (trap_hit) begin
      trap_pc_q   <= pc;
      trap_word_q <= instr;
    end
  end

  // R5: a trap and a write never share a cycle
  a_r5_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> !wr_en_q);

  // R8: trap report holds between traps
  a_r8_trap_report_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_q |-> ($stable(trap_pc_q) && $stable(trap_word_q)));

  // R8: result and index hold between writes
  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_q |-> ($stable(result_q) && $stable(dest_q)));

endmodule

// File: rtl/simd_copy_unit.sv
module simd_copy_unit
  import scd_pkg::*;
#(
  parameter int XLEN = 128,
  parameter int PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [XLEN-1:0]      src_a_i,
  input  logic [XLEN-1:0]      src_b_i,
  output logic [XLEN-1:0]      result_o,
  output logic [REG_IDX_W-1:0] dest_o,
  output logic                 wr_en_o,
  output logic                 trap_o,
  output logic [PC_W-1:0]      trap_pc_o,
  output logic [INSTR_W-1:0]   trap_word_o
);

  localparam int LANE = XLEN / 2;

  action_e              dec_action;
  logic                 dec_copy;
  logic                 dec_trap;
  logic                 dec_write;
  logic [REG_IDX_W-1:0] dec_dst;
  logic [XLEN-1:0]      lane_value;
  logic [2*(XLEN-LANE)-1:0] unused_upper_lanes;

  // Only the lower lanes feed the copy; upper halves are architecturally dropped.
  assign unused_upper_lanes = {src_a_i[XLEN-1:LANE], src_b_i[XLEN-1:LANE]};

  scd_decode u_decode (
    .valid     (valid_i),
    .instr     (instr_i),
    .action    (dec_action),
    .copy_hit  (dec_copy),
    .trap_hit  (dec_trap),
    .write_req (dec_write),
    .dst_idx   (dec_dst)
  );

  scd_lane_cross #(.XLEN(XLEN)) u_lanes (
    .hi_lane_src (src_a_i[LANE-1:0]),
    .lo_lane_src (src_b_i[LANE-1:0]),
    .merged      (lane_value)
  );

  scd_commit #(.XLEN(XLEN), .PC_W(PC_W)) u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .write_req   (dec_write),
    .trap_hit    (dec_trap),
    .value       (lane_value),
    .dst_idx     (dec_dst),
    .pc          (pc_i),
    .instr       (instr_i),
    .result_q    (result_o),
    .dest_q      (dest_o),
    .wr_en_q     (wr_en_o),
    .trap_q      (trap_o),
    .trap_pc_q   (trap_pc_o),
    .trap_word_q (trap_word_o)
  );

  // R4: index 0 is never written
  a_r4_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (dest_o != '0));

  // R2: a copy arm decode produces no trap in the next cycle
  a_r2_copy_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    dec_copy |=> !trap_o);

  // R3: upper lane of the result came from the lower lane of the first source
  a_r3_upper_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (result_o[XLEN-1:LANE] == $past(src_a_i[LANE-1:0])));

  // R3: lower lane of the result came from the lower lane of the second source
  a_r3_lower_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (result_o[LANE-1:0] == $past(src_b_i[LANE-1:0])));

  // R6: foreign opcodes never write or trap
  a_r6_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_action == ACT_PASS) |=> (!wr_en_o && !trap_o));

  // R7: no valid input, no strobe next cycle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!wr_en_o && !trap_o));

  // R5: trap report names the instruction that trapped
  a_r5_trap_word: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (trap_word_o == $past(instr_i) && trap_pc_o == $past(pc_i)));

endmodule

// File: tb/simd_copy_unit_test.sv
module simd_copy_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 128;
  localparam int WATCHDOG_CYCLES = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic [31:0]      instr_i = '0;
  logic [31:0]      pc_i = '0;
  logic [XLEN-1:0]  src_a_i = '0;
  logic [XLEN-1:0]  src_b_i = '0;
  logic [XLEN-1:0]  result_o;
  logic [4:0]       dest_o;
  logic             wr_en_o;
  logic             trap_o;
  logic [31:0]      trap_pc_o;
  logic [31:0]      trap_word_o;

  simd_copy_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .result_o(result_o), .dest_o(dest_o), .wr_en_o(wr_en_o),
    .trap_o(trap_o), .trap_pc_o(trap_pc_o), .trap_word_o(trap_word_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int              due;
    string           req;
    logic            wen;
    logic            trap;
    logic [XLEN-1:0] result;
    logic [4:0]      dest;
    logic [31:0]     tpc;
    logic [31:0]     tword;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;

  // reference state kept by the bench
  logic [XLEN-1:0] m_result = '0;
  logic [4:0]      m_dest = '0;
  logic [31:0]     m_tpc = '0;
  logic [31:0]     m_tword = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd,
                                     input logic [4:0] sa, input logic [5:0] fn);
    return {op, rs, rt, rd, sa, fn};
  endfunction

  // Driver: present one cycle of stimulus and push what must appear after the next edge.
  task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] pc,
                      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input string req);
    exp_t e;
    bit media, copy_arm;
    @(posedge clk);
    #1;
    valid_i = v; instr_i = ins; pc_i = pc; src_a_i = a; src_b_i = b;
    media    = v && (ins[31:26] == 6'h1C);
    copy_arm = media && (ins[5:0] == 6'h09) && (ins[10:6] == 5'h0E);
    e.wen  = copy_arm && (ins[15:11] != 5'd0);
    e.trap = media && !copy_arm;
    if (e.wen) begin
      m_result = {a[63:0], b[63:0]};
      m_dest   = ins[15:11];
    end
    if (e.trap) begin
      m_tpc   = pc;
      m_tword = ins;
    end
    e.due = cyc + 1; e.req = req;
    e.result = m_result; e.dest = m_dest; e.tpc = m_tpc; e.tword = m_tword;
    q.push_back(e);
  endtask

  // Monitor: compare each due item shortly after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(wr_en_o == e.wen,  e.req, "wr_en",  XLEN'(wr_en_o), XLEN'(e.wen));
        check(trap_o == e.trap,  e.req, "trap",   XLEN'(trap_o),  XLEN'(e.trap));
        check(result_o == e.result, e.req, "result", result_o, e.result);
        check(dest_o == e.dest,  e.req, "dest",   XLEN'(dest_o),  XLEN'(e.dest));
        check(trap_pc_o == e.tpc, e.req, "trap_pc", XLEN'(trap_pc_o), XLEN'(e.tpc));
        check(trap_word_o == e.tword, e.req, "trap_word", XLEN'(trap_word_o), XLEN'(e.tword));
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [XLEN-1:0] A1 = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0011_2233;
  localparam logic [XLEN-1:0] B1 = 128'hFACE_FEED_7654_3210_4455_6677_8899_AABB;

  initial begin
    // R1: reset values
    repeat (3) @(posedge clk);
    #2;
    check(!wr_en_o && !trap_o, "R1", "strobes", XLEN'({wr_en_o, trap_o}), '0);
    check(result_o == '0 && dest_o == '0, "R1", "result", result_o, '0);
    check(trap_pc_o == '0 && trap_word_o == '0, "R1", "trap report", XLEN'(trap_pc_o), '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, '0, '0, '0, '0, "R1");

    // R2 R3: basic copy, upper source halves must not matter
    step(1, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h0E, 6'h09), 32'h0011_2C84, A1, B1, "R2");
    step(1, mk(6'h1C, 5'd1, 5'd2, 5'd31, 5'h0E, 6'h09), 32'h0000_1000,
         {64'hFFFF_FFFF_FFFF_FFFF, A1[63:0]}, {64'h0, B1[63:0]}, "R3");
    for (int i = 0; i < 8; i++) begin
      logic [XLEN-1:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      step(1, mk(6'h1C, 5'(i), 5'(i + 3), 5'(i + 1), 5'h0E, 6'h09), 32'h2000 + 32'(i * 4),
           a, b, "R3");
    end

    // R4: destination 0, held outputs must stay
    step(1, mk(6'h1C, 5'd4, 5'd6, 5'd0, 5'h0E, 6'h09), 32'h3000, B1, A1, "R4");
    step(0, '0, '0, '0, '0, "R4");

    // R5: every non-copy arm of the extension space traps
    step(1, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h0F, 6'h09), 32'h4000, A1, B1, "R5");
    step(1, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h0D, 6'h09), 32'h4004, A1, B1, "R5");
    step(1, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h0E, 6'h08), 32'h4008, A1, B1, "R5");
    step(1, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h0E, 6'h28), 32'h400C, A1, B1, "R5");
    step(1, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h0E, 6'h29), 32'h4010, A1, B1, "R5");
    step(1, mk(6'h1C, 5'd0, 5'd0, 5'd0, 5'h00, 6'h00), 32'h4014, A1, B1, "R5");
    step(1, mk(6'h1C, 5'd5, 5'd9, 5'd0, 5'h03, 6'h09), 32'h4018, A1, B1, "R5");

    // R6: foreign opcodes, including ones whose low fields mimic the copy
    step(1, mk(6'h00, 5'd5, 5'd9, 5'd10, 5'h0E, 6'h09), 32'h5000, B1, A1, "R6");
    step(1, mk(6'h1D, 5'd5, 5'd9, 5'd10, 5'h0E, 6'h09), 32'h5004, B1, A1, "R6");
    step(1, mk(6'h15, 5'd8, 5'd9, 5'd3, 5'h00, 6'h00), 32'h5008, B1, A1, "R6");

    // R7: copy pattern present but not valid
    step(0, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h0E, 6'h09), 32'h6000, B1, A1, "R7");
    step(0, mk(6'h1C, 5'd5, 5'd9, 5'd10, 5'h1F, 6'h09), 32'h6004, B1, A1, "R7");

    // R8: back-to-back mix, reports hold across intervening cycles
    step(1, mk(6'h1C, 5'd2, 5'd3, 5'd7, 5'h0E, 6'h09), 32'h7000, B1, A1, "R8");
    step(1, mk(6'h1C, 5'd2, 5'd3, 5'd7, 5'h01, 6'h29), 32'h7004, A1, B1, "R8");
    step(1, mk(6'h1C, 5'd2, 5'd3, 5'd8, 5'h0E, 6'h09), 32'h7008, A1, B1, "R8");
    step(1, mk(6'h08, 5'd2, 5'd3, 5'd8, 5'h0E, 6'h09), 32'h700C, B1, B1, "R8");
    step(0, '0, '0, '0, '0, "R8");
    step(0, '0, '0, '0, '0, "R8");

    repeat (3) @(posedge clk);
    #3;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule